// File: doc/BRIEF.md
# Dirty Cache Line Range Tracker

This block follows writes into a data cache and remembers the smallest and the largest line index that has been marked dirty since the last flush or full clean. A clean or flush routine reads these two bounds and walks only the lines between them. This saves time when only a few lines are dirty. The cache arrays, the TLBs and the bus controller are outside the block. Their events arrive as single-cycle input pulses.

The block also keeps a small status word. One flag reports that the cache may hold dirty data. Two sticky flags record an external abort and an abort on a write that was drained from the write buffer; a read of the status word clears both. A fourth bit copies the write-buffer-full input. Software reads the min register, the max register and the status word through one registered read port.

Top module: `dirty_range_tracker`

## Requirements
- R1: On a cycle with `wr_valid=1` and `wr_dirty=1`, the max bound becomes `wr_idx` if `wr_idx` is greater than the current max. In the same cycle, the min bound becomes `wr_idx` if `wr_idx` is less than the current min.
- R2: After reset the min bound has every bit set, the max bound is zero and all status bits are zero.
- R3: A `flush_req` or `clean_done` pulse returns min to all ones, max to zero and the dirty flag to zero. It takes precedence over a dirty write in the same cycle.
- R4: Status bit 0 (may-be-dirty) is set by the first dirty write after a reset, flush or clean, and it is cleared only by those three. While it is 0, min is greater than max.
- R5: A write event with `wr_dirty=0` changes neither bound nor the dirty flag.
- R6: `ext_abort` sets status bit 1 and `wb_abort` sets status bit 2. Both bits stay set until they are cleared.
- R7: A status read returns the bits as they were before the read, then clears bits 1 and 2. An abort that arrives in the same cycle as the read leaves its bit set.
- R8: Status bit 3 equals the value `wb_full` had on the previous clock edge.
- R9: `rd_data` is loaded on the clock edge at which `rd_en=1` and then holds that value. `rd_sel` 0 selects min, 1 selects max, 2 selects status and 3 returns zero. Bits above the index width (for min and max) and above bit 3 (for status) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Line write event strobe |
| wr_idx | input | IDX_W | Line index of the write event |
| wr_dirty | input | 1 | The write event marks the line dirty |
| flush_req | input | 1 | Data cache flush pulse |
| clean_done | input | 1 | Full clean completed pulse |
| ext_abort | input | 1 | External abort pulse |
| wb_abort | input | 1 | Abort on a drained buffered write |
| wb_full | input | 1 | Write buffer full level |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select: 0 min, 1 max, 2 status, 3 none |
| rd_data | output | REG_W | Registered read data |

## Verification
The assertions check on every cycle that the bounds stay ordered while the dirty flag is set and sit at their reset values while it is clear. They also check that a flush or clean resets the bounds, that a dirty write stays inside the bounds, that an abort sets its bit, and that the full bit follows its input. The bench scenarios show what a property cannot capture well: the read values after sequences of writes at the index extremes, that non-dirty writes have no effect, that a flush wins over a write in the same cycle, and the exact ordering of clear-on-read against an abort in the same cycle.

// File: rtl/drt_pkg.sv
// Package: shared select codes and status bit positions for the dirty range tracker.
// Assumes: status word is at most REG_W bits wide; positions fixed below.
package drt_pkg;
    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_MAX  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int ST_DIRTY = 0;
    localparam int ST_EXT   = 1;
    localparam int ST_WBA   = 2;
    localparam int ST_FULL  = 3;
    localparam int ST_W     = 4;
endpackage

// File: rtl/drt_bounds.sv
// Module: drt_bounds
// Keeps the lowest and highest dirty line index and the may-be-dirty flag.
// Assumes: clear_req has priority over a same-cycle dirty mark.
module drt_bounds #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_dirty,
    input  logic [IDX_W-1:0] idx,
    input  logic             clear_req,
    output logic [IDX_W-1:0] min_o,
    output logic [IDX_W-1:0] max_o,
    output logic             dirty_o
);
    localparam logic [IDX_W-1:0] MIN_INIT = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] MAX_INIT = '0;

    logic [IDX_W-1:0] min_q, max_q;
    logic             dirty_q;
    logic             below_min, above_max;

    // Purpose: compare the incoming index against both bounds in parallel.
    always_comb begin
        below_min = idx < min_q;
        above_max = idx > max_q;
    end

    // Purpose: update bounds and dirty flag; reset/clear restore initial values.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_req) begin
            min_q   <= MIN_INIT;
            max_q   <= MAX_INIT;
            dirty_q <= 1'b0;
        end else if (mark_dirty) begin
            if (below_min) min_q <= idx;
            if (above_max) max_q <= idx;
            dirty_q <= 1'b1;
        end
    end

    assign min_o   = min_q;
    assign max_o   = max_q;
    assign dirty_o = dirty_q;
endmodule

// File: rtl/drt_status.sv
// Module: drt_status
// Sticky abort flags with clear-on-read and a registered copy of buffer-full.
// Assumes: a set event in the same cycle as a read clear wins.
module drt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_abort,
    input  logic wb_abort,
    input  logic wb_full,
    input  logic rd_clear,
    output logic ext_o,
    output logic wba_o,
    output logic full_o
);
    logic ext_q, wba_q, full_q;

    // Purpose: sticky external abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         ext_q <= 1'b0;
        else if (ext_abort) ext_q <= 1'b1;
        else if (rd_clear)  ext_q <= 1'b0;
    end

    // Purpose: sticky buffered-write abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        wba_q <= 1'b0;
        else if (wb_abort) wba_q <= 1'b1;
        else if (rd_clear) wba_q <= 1'b0;
    end

    // Purpose: register the write-buffer-full level.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= wb_full;
    end

    assign ext_o  = ext_q;
    assign wba_o  = wba_q;
    assign full_o = full_q;
endmodule

// File: rtl/drt_readmux.sv
// Module: drt_readmux
// Selects min, max or status and registers it onto the read data bus.
// Assumes: IDX_W <= REG_W and status width <= REG_W; upper bits zero-filled.
module drt_readmux
    import drt_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic [IDX_W-1:0] min_i,
    input  logic [IDX_W-1:0] max_i,
    input  logic [ST_W-1:0]  stat_i,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] min_ext, max_ext, stat_ext, sel_word;

    generate
        if (IDX_W < REG_W) begin : g_pad_idx
            assign min_ext = {{(REG_W-IDX_W){1'b0}}, min_i};
            assign max_ext = {{(REG_W-IDX_W){1'b0}}, max_i};
        end else begin : g_full_idx
            assign min_ext = min_i[REG_W-1:0];
            assign max_ext = max_i[REG_W-1:0];
        end
    endgenerate

    assign stat_ext = {{(REG_W-ST_W){1'b0}}, stat_i};

    // Purpose: decode the register select.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_MIN:  sel_word = min_ext;
            SEL_MAX:  sel_word = max_ext;
            SEL_STAT: sel_word = stat_ext;
            default:  sel_word = '0;
        endcase
    end

    // Purpose: capture the selected word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end
endmodule

// File: rtl/dirty_range_tracker.sv
// Module: dirty_range_tracker (top)
// Tracks the dirty line index range of a data cache plus a sticky status word.
// Assumes: all event inputs are synchronous single-cycle pulses.
module dirty_range_tracker
    import drt_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_dirty,
    input  logic             flush_req,
    input  logic             clean_done,
    input  logic             ext_abort,
    input  logic             wb_abort,
    input  logic             wb_full,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data
);
    logic [IDX_W-1:0] min_w, max_w;
    logic             dirty_w, ext_w, wba_w, full_w;
    logic             mark_w, clear_w, rd_clear_w;
    logic [ST_W-1:0]  stat_w;

    // Purpose: derive strobes for the sub-blocks.
    always_comb begin
        mark_w     = wr_valid && wr_dirty;
        clear_w    = flush_req || clean_done;
        rd_clear_w = rd_en && (rd_sel == SEL_STAT);
    end

    // Purpose: assemble the status word.
    always_comb begin
        stat_w           = '0;
        stat_w[ST_DIRTY] = dirty_w;
        stat_w[ST_EXT]   = ext_w;
        stat_w[ST_WBA]   = wba_w;
        stat_w[ST_FULL]  = full_w;
    end

    drt_bounds #(.IDX_W(IDX_W)) u_bounds (
        .clk(clk), .rst_n(rst_n), .mark_dirty(mark_w), .idx(wr_idx),
        .clear_req(clear_w), .min_o(min_w), .max_o(max_w), .dirty_o(dirty_w)
    );

    drt_status u_status (
        .clk(clk), .rst_n(rst_n), .ext_abort(ext_abort), .wb_abort(wb_abort),
        .wb_full(wb_full), .rd_clear(rd_clear_w),
        .ext_o(ext_w), .wba_o(wba_w), .full_o(full_w)
    );

    drt_readmux #(.IDX_W(IDX_W), .REG_W(REG_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .min_i(min_w), .max_i(max_w), .stat_i(stat_w), .rd_data(rd_data)
    );
endmodule

// File: rtl/drt_checker.sv
// Module: drt_checker
// Concurrent properties on the tracker, bound into every dirty_range_tracker.
module drt_checker #(
    parameter int IDX_W = 8,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [IDX_W-1:0] wr_idx,
    input logic             wr_dirty,
    input logic             flush_req,
    input logic             clean_done,
    input logic             ext_abort,
    input logic             wb_abort,
    input logic             wb_full,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic [REG_W-1:0] rd_data,
    input logic [IDX_W-1:0] min_w,
    input logic [IDX_W-1:0] max_w,
    input logic             dirty_w,
    input logic             ext_w,
    input logic             wba_w,
    input logic             full_w
);
    localparam logic [IDX_W-1:0] ONES = {IDX_W{1'b1}};

    p_reset_vals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (min_w == ONES && max_w == '0 && !dirty_w && !ext_w && !wba_w));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req || clean_done) |=> (min_w == ONES && max_w == '0 && !dirty_w));

    p_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_dirty && !flush_req && !clean_done) |=>
        (max_w >= $past(wr_idx) && min_w <= $past(wr_idx) && dirty_w));

    p_ordered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_w |-> (min_w <= max_w));

    p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dirty_w |-> (min_w == ONES && max_w == '0));

    p_ext_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_abort |=> ext_w);

    p_wba_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_abort |=> wba_w);

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd2 && !ext_abort && !wb_abort) |=> (!ext_w && !wba_w));

    p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (full_w == $past(wb_full)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rd_data));
endmodule

bind dirty_range_tracker drt_checker #(.IDX_W(IDX_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_dirty(wr_dirty), .flush_req(flush_req), .clean_done(clean_done),
    .ext_abort(ext_abort), .wb_abort(wb_abort), .wb_full(wb_full),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .min_w(min_w), .max_w(max_w), .dirty_w(dirty_w),
    .ext_w(ext_w), .wba_w(wba_w), .full_w(full_w)
);

// File: tb/dirty_range_tracker_tb_top.sv
module dirty_range_tracker_tb_top;
    localparam int IDX_W = 8;
    localparam int REG_W = 32;
    localparam logic [IDX_W-1:0] ONES = {IDX_W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_dirty = 0, flush_req = 0, clean_done = 0;
    logic ext_abort = 0, wb_abort = 0, wb_full = 0, rd_en = 0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [1:0] rd_sel = '0;
    logic [REG_W-1:0] rd_data;

    always #2.5 clk = ~clk;

    dirty_range_tracker #(.IDX_W(IDX_W), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_dirty(wr_dirty), .flush_req(flush_req), .clean_done(clean_done),
        .ext_abort(ext_abort), .wb_abort(wb_abort), .wb_full(wb_full),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    typedef struct {
        logic [REG_W-1:0] exp;
        string            req;
    } item_t;
    item_t sb_q[$];

    int total = 0, bad = 0;
    string cur_req = "R2";

    // reference model state
    logic [IDX_W-1:0] m_min = ONES, m_max = '0;
    logic m_dirty = 0, m_ext = 0, m_wba = 0, m_full = 0;

    function automatic logic [REG_W-1:0] model_word(input logic [1:0] s);
        case (s)
            2'd0: return REG_W'(m_min);
            2'd1: return REG_W'(m_max);
            2'd2: return REG_W'({m_full, m_wba, m_ext, m_dirty});
            default: return '0;
        endcase
    endfunction

    // driver: one clock with the currently driven inputs
    task automatic tick();
        logic rclr;
        if (rd_en) sb_q.push_back('{model_word(rd_sel), cur_req});
        rclr = rd_en && rd_sel == 2'd2;
        @(posedge clk);
        if (!rst_n || flush_req || clean_done) begin
            m_min = ONES; m_max = '0; m_dirty = 0;
        end else if (wr_valid && wr_dirty) begin
            if (wr_idx > m_max) m_max = wr_idx;
            if (wr_idx < m_min) m_min = wr_idx;
            m_dirty = 1;
        end
        if (!rst_n) begin m_ext = 0; m_wba = 0; m_full = 0; end
        else begin
            if (ext_abort) m_ext = 1; else if (rclr) m_ext = 0;
            if (wb_abort) m_wba = 1; else if (rclr) m_wba = 0;
            m_full = wb_full;
        end
        @(negedge clk);
        wr_valid = 0; wr_dirty = 0; flush_req = 0; clean_done = 0;
        ext_abort = 0; wb_abort = 0; rd_en = 0;
    endtask

    task automatic wr(input logic [IDX_W-1:0] i, input logic d);
        wr_valid = 1; wr_idx = i; wr_dirty = d; tick();
    endtask

    task automatic rd(input logic [1:0] s, input string r);
        cur_req = r; rd_en = 1; rd_sel = s; tick();
    endtask

    task automatic rd_all(input string r);
        rd(2'd0, r); rd(2'd1, r); rd(2'd2, r);
    endtask

    // monitor: compares read data one edge after each strobe
    logic rd_seen = 0;
    always @(posedge clk) rd_seen <= rd_en && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL %s: read with empty scoreboard, actual=%h expected=none", cur_req, rd_data);
            end else begin
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        fork
            begin
                @(negedge clk);
                tick(); tick();
                rst_n = 1;
                // R2 reset values, R9 select 3 returns zero
                rd_all("R2");
                rd(2'd3, "R9");
                // R1 first dirty write sets both bounds, R4 flag
                wr(8'h40, 1);
                rd_all("R1");
                // R5 non-dirty writes have no effect
                wr(8'h05, 0); wr(8'hF0, 0);
                rd_all("R5");
                // R1 widening
                wr(8'h10, 1); wr(8'h90, 1); wr(8'h20, 1);
                rd_all("R1");
                // R1 extremes
                wr(8'h00, 1); wr(8'hFF, 1);
                rd_all("R1");
                // R3 flush
                flush_req = 1; tick();
                rd_all("R3");
                // R4 idx 0 only: min=0 max=0
                wr(8'h00, 1);
                rd_all("R4");
                // R3 clean_done wins over same-cycle dirty write
                clean_done = 1; wr(8'h33, 1);
                rd_all("R3");
                // R6 sticky aborts
                ext_abort = 1; tick();
                tick(); tick();
                rd(2'd2, "R6");
                rd(2'd2, "R7");
                wb_abort = 1; tick();
                rd(2'd2, "R6");
                rd(2'd2, "R7");
                // R7 abort on the cycle of the read survives
                ext_abort = 1; wb_abort = 1; rd(2'd2, "R7");
                rd(2'd2, "R7");
                rd(2'd2, "R7");
                // R8 buffer-full mirror
                wb_full = 1; tick();
                rd(2'd2, "R8");
                wb_full = 0; rd(2'd2, "R8");
                rd(2'd2, "R8");
                // R9 rd_data holds while no read
                rd(2'd1, "R9");
                wr(8'h77, 1);
                tick();
                total++;
                if (rd_data !== 32'h0) begin
                    bad++;
                    $display("FAIL R9: hold actual=%h expected=%h", rd_data, 32'h0);
                end
                rd(2'd1, "R9");
                tick(); tick();
                if (sb_q.size() != 0) begin
                    total++; bad++;
                    $display("FAIL R9: %0d reads never returned, actual=%0d expected=0", sb_q.size(), sb_q.size());
                end
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule